// File: doc/BRIEF.md
# Scan Shift Transition-Rate Monitor

This block watches a group of scan chains while they shift and estimates, one shift cycle at a time, how much switching the shift causes. Each chain is modelled inside the block as a shift register. On every accepted shift beat it counts the cells that change value, whether they rise or fall. It then checks that count, taken as a fraction of all cells, against a programmable percentage ceiling. In the same beat it counts the chains whose gate bit is set and checks that fraction against a second ceiling. Neither check uses a divider.

The shift data arrive on a valid/ready stream carrying one scan-in bit per chain and the gating vector for that beat. The block never applies back-pressure: `in_ready` is high in every cycle outside reset. A beat is accepted in any cycle where `in_valid` and `in_ready` are both high. A gated-off chain (gate 0) loads a constant 0 in place of its scan-in bit. A one-cycle `pattern_start` pulse opens a new pattern. It clears the sticky high-power flag, the sticky activation flag and the running peak of the toggle count.

Top module: `scan_tr_monitor`

## Requirements
- R1: `in_ready` is 0 while `rst` is high and 1 otherwise. `cyc_toggles`, `act_chains`, `peak_toggles` and both flags keep their values in any cycle with no accepted beat and no `pattern_start`.
- R2: On an accepted beat, chain c shifts by one position. Cell 0 loads `scan_in[c] & chain_gate[c]`, and cell k loads the old value of cell k-1. A chain with gate 0 therefore shifts in 0.
- R3: After an accepted beat, `cyc_toggles` equals the number of cells, over all chains, whose value after the shift differs from their value before it.
- R4: After an accepted beat, `act_chains` equals the number of 1 bits in the `chain_gate` vector of that beat.
- R5: `hp_flag` is set by an accepted beat whose toggle count t satisfies t*100 > `max_tr_pct`*CHAINS*CELLS. Once set, it stays set until the next `pattern_start`.
- R6: `act_flag` is set by an accepted beat whose active-chain count a satisfies a*100 > `max_act_pct`*CHAINS. Once set, it stays set until the next `pattern_start`.
- R7: `peak_toggles` holds the largest `cyc_toggles` value produced by any accepted beat since the last `pattern_start`.
- R8: `pattern_start` clears `hp_flag`, `act_flag` and `peak_toggles` on the next edge. A beat accepted in the same cycle counts toward the new pattern.
- R9: Reset (synchronous, active high) sets every modelled cell to 0 and sets all counts and flags to 0.
- R10: A rate exactly equal to its ceiling (product equality) does not set either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A shift beat is offered |
| in_ready | output | 1 | Beat can be accepted (high whenever out of reset) |
| scan_in | input | CHAINS | One scan-in bit per chain |
| chain_gate | input | CHAINS | Per-chain enable; 0 forces a 0 into that chain |
| pattern_start | input | 1 | One-cycle pulse starting a new pattern |
| max_tr_pct | input | 7 | Toggle-rate ceiling in percent |
| max_act_pct | input | 7 | Chain-activation ceiling in percent |
| cyc_toggles | output | clog2(CHAINS*CELLS+1) | Toggle count of the last accepted beat |
| act_chains | output | clog2(CHAINS+1) | Active-chain count of the last accepted beat |
| peak_toggles | output | clog2(CHAINS*CELLS+1) | Largest toggle count in the current pattern |
| hp_flag | output | 1 | Sticky: toggle rate exceeded in this pattern |
| act_flag | output | 1 | Sticky: activation rate exceeded in this pattern |

## Verification
The bench builds the block with CHAINS=3 and CELLS=4, which gives a 12-cell array. It drives every combination of the three scan-in bits and the three gate bits, and repeats that sequence for every toggle-rate ceiling from 0 to 100 percent, with an activation ceiling that varies alongside it. Such a small array makes it cheap to hit every equality point of both comparisons (for example 3 toggles against 25 percent), so the strict-greater rule is tested at each boundary. Idle beats and pattern starts are mixed into the sweep, some on their own and some together with a shift, so the hold behaviour and the clearing order are both exercised.

// File: rtl/scan_mon_pkg.sv
package scan_mon_pkg;
  // Width of a percentage limit input (0..100 fits in 7 bits).
  localparam int PCT_W = 7;
  // Scale factor used on the count side of the cross-multiplied compare.
  localparam int PCT_FULL = 100;
endpackage

// File: rtl/scan_chain_bank.sv
module scan_chain_bank #(
  parameter int CHAINS = 8,
  parameter int CELLS  = 16,
  localparam int TOTAL = CHAINS * CELLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic [CHAINS-1:0] scan_in,
  input  logic [CHAINS-1:0] chain_gate,
  output logic [TOTAL-1:0]  cur_flat,
  output logic [TOTAL-1:0]  nxt_flat
);
  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    logic [CELLS-1:0] q;
    logic [CELLS-1:0] d;
    logic             din;

    // Gated chains receive a constant zero.
    assign din = scan_in[c] & chain_gate[c];

    if (CELLS == 1) begin : g_single
      assign d = din;
    end else begin : g_multi
      assign d = {q[CELLS-2:0], din};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (shift) begin
        q <= d;
      end
    end

    assign cur_flat[c*CELLS +: CELLS] = q;
    assign nxt_flat[c*CELLS +: CELLS] = d;
  end
endmodule

// File: rtl/bit_popcount.sv
module bit_popcount #(
  parameter int N = 16,
  localparam int W = $clog2(N + 1)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + W'(vec[i]);
    end
  end
endmodule

// File: rtl/rate_limit_cmp.sv
module rate_limit_cmp
  import scan_mon_pkg::*;
#(
  parameter int DEN = 16,
  localparam int CW = $clog2(DEN + 1),
  localparam int MW = CW + PCT_W + 1
) (
  input  logic [CW-1:0]    count,
  input  logic [PCT_W-1:0] limit_pct,
  output logic             over
);
  logic [MW-1:0] lhs;
  logic [MW-1:0] rhs;

  // count/DEN > pct/100  <=>  count*100 > pct*DEN
  always_comb begin
    lhs  = MW'(count) * MW'(PCT_FULL);
    rhs  = MW'(limit_pct) * MW'(DEN);
    over = lhs > rhs;
  end
endmodule

// File: rtl/scan_tr_monitor.sv
module scan_tr_monitor
  import scan_mon_pkg::*;
#(
  parameter int CHAINS = 8,
  parameter int CELLS  = 16,
  localparam int TOTAL = CHAINS * CELLS,
  localparam int TW    = $clog2(TOTAL + 1),
  localparam int AW    = $clog2(CHAINS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAINS-1:0] scan_in,
  input  logic [CHAINS-1:0] chain_gate,
  input  logic              pattern_start,
  input  logic [PCT_W-1:0]  max_tr_pct,
  input  logic [PCT_W-1:0]  max_act_pct,
  output logic [TW-1:0]     cyc_toggles,
  output logic [AW-1:0]     act_chains,
  output logic [TW-1:0]     peak_toggles,
  output logic              hp_flag,
  output logic              act_flag
);
  logic             accept;
  logic [TOTAL-1:0] cur_flat;
  logic [TOTAL-1:0] nxt_flat;
  logic [TOTAL-1:0] diff_vec;
  logic [TW-1:0]    tog_now;
  logic [AW-1:0]    act_now;
  logic             tr_over;
  logic             act_over;
  logic [TW-1:0]    peak_base;

  assign in_ready = !rst;
  assign accept   = in_valid && in_ready;

  scan_chain_bank #(.CHAINS(CHAINS), .CELLS(CELLS)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .shift      (accept),
    .scan_in    (scan_in),
    .chain_gate (chain_gate),
    .cur_flat   (cur_flat),
    .nxt_flat   (nxt_flat)
  );

  assign diff_vec = cur_flat ^ nxt_flat;

  bit_popcount #(.N(TOTAL)) u_tog_cnt (
    .vec   (diff_vec),
    .count (tog_now)
  );

  bit_popcount #(.N(CHAINS)) u_act_cnt (
    .vec   (chain_gate),
    .count (act_now)
  );

  rate_limit_cmp #(.DEN(TOTAL)) u_tr_cmp (
    .count     (tog_now),
    .limit_pct (max_tr_pct),
    .over      (tr_over)
  );

  rate_limit_cmp #(.DEN(CHAINS)) u_act_cmp (
    .count     (act_now),
    .limit_pct (max_act_pct),
    .over      (act_over)
  );

  assign peak_base = pattern_start ? '0 : peak_toggles;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_toggles  <= '0;
      act_chains   <= '0;
      peak_toggles <= '0;
      hp_flag      <= 1'b0;
      act_flag     <= 1'b0;
    end else begin
      if (accept) begin
        cyc_toggles <= tog_now;
        act_chains  <= act_now;
      end
      if (accept && (tog_now > peak_base)) begin
        peak_toggles <= tog_now;
      end else begin
        peak_toggles <= peak_base;
      end
      hp_flag  <= (hp_flag  && !pattern_start) || (accept && tr_over);
      act_flag <= (act_flag && !pattern_start) || (accept && act_over);
    end
  end
endmodule

// File: rtl/scan_tr_monitor_chk.sv
module scan_tr_monitor_chk
  import scan_mon_pkg::*;
#(
  parameter int CHAINS = 8,
  parameter int CELLS  = 16,
  localparam int TOTAL = CHAINS * CELLS,
  localparam int TW    = $clog2(TOTAL + 1),
  localparam int AW    = $clog2(CHAINS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              pattern_start,
  input logic [TW-1:0]     cyc_toggles,
  input logic [AW-1:0]     act_chains,
  input logic [TW-1:0]     peak_toggles,
  input logic              hp_flag,
  input logic              act_flag
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!acc && !pattern_start) |=> ($stable(cyc_toggles) && $stable(act_chains)
      && $stable(peak_toggles) && $stable(hp_flag) && $stable(act_flag)));

  p_tog_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cyc_toggles <= TW'(TOTAL));

  p_act_bound_r4: assert property (@(posedge clk) disable iff (rst)
    act_chains <= AW'(CHAINS));

  p_hp_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (hp_flag && !pattern_start) |=> hp_flag);

  p_hp_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hp_flag) |-> $past(acc));

  p_act_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (act_flag && !pattern_start) |=> act_flag);

  p_peak_cover_r7: assert property (@(posedge clk) disable iff (rst)
    acc |=> (peak_toggles >= cyc_toggles));

  p_peak_mono_r7: assert property (@(posedge clk) disable iff (rst)
    !pattern_start |=> (peak_toggles >= $past(peak_toggles)));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (pattern_start && !acc) |=> (!hp_flag && !act_flag && peak_toggles == '0));
endmodule

bind scan_tr_monitor scan_tr_monitor_chk #(.CHAINS(CHAINS), .CELLS(CELLS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .pattern_start (pattern_start),
  .cyc_toggles   (cyc_toggles),
  .act_chains    (act_chains),
  .peak_toggles  (peak_toggles),
  .hp_flag       (hp_flag),
  .act_flag      (act_flag)
);

// File: tb/tb_scan_tr_monitor.sv
`timescale 1ns/1ps
module tb_scan_tr_monitor;
  localparam int NC = 3;
  localparam int NL = 4;
  localparam int NT = NC * NL;
  localparam int TW = $clog2(NT + 1);
  localparam int AW = $clog2(NC + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [NC-1:0] scan_in;
  logic [NC-1:0] chain_gate;
  logic          pattern_start;
  logic [6:0]    max_tr_pct;
  logic [6:0]    max_act_pct;
  logic [TW-1:0] cyc_toggles;
  logic [AW-1:0] act_chains;
  logic [TW-1:0] peak_toggles;
  logic          hp_flag;
  logic          act_flag;

  always #5 clk = ~clk;

  scan_tr_monitor #(.CHAINS(NC), .CELLS(NL)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .scan_in(scan_in), .chain_gate(chain_gate), .pattern_start(pattern_start),
    .max_tr_pct(max_tr_pct), .max_act_pct(max_act_pct),
    .cyc_toggles(cyc_toggles), .act_chains(act_chains),
    .peak_toggles(peak_toggles), .hp_flag(hp_flag), .act_flag(act_flag)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [NL-1:0] mq [NC];
  int e_cyc, e_act, e_peak;
  bit e_hp, e_af;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [NC-1:0] si, input logic [NC-1:0] g,
                      input bit st, input int trp, input int ap);
    int tog;
    int act;
    string hp_tag;
    string af_tag;
    in_valid      = v;
    scan_in       = si;
    chain_gate    = g;
    pattern_start = st;
    max_tr_pct    = 7'(trp);
    max_act_pct   = 7'(ap);
    hp_tag = "R5 hp_flag";
    af_tag = "R6 act_flag";
    @(posedge clk);
    if (st) begin
      e_peak = 0; e_hp = 0; e_af = 0;
    end
    if (v) begin
      tog = 0;
      act = 0;
      for (int c = 0; c < NC; c++) begin
        logic [NL-1:0] nq;
        logic din;
        din = si[c] & g[c];
        nq = {mq[c][NL-2:0], din};
        for (int k = 0; k < NL; k++) tog += int'(nq[k] != mq[c][k]);
        mq[c] = nq;
        act += int'(g[c]);
      end
      e_cyc = tog;
      e_act = act;
      if (tog > e_peak) e_peak = tog;
      if (tog * 100 > trp * NT) e_hp = 1;
      if (act * 100 > ap * NC) e_af = 1;
      if (tog * 100 == trp * NT) hp_tag = "R10 hp_flag at equality";
      if (act * 100 == ap * NC) af_tag = "R10 act_flag at equality";
    end
    @(negedge clk);
    in_valid = 1'b0;
    pattern_start = 1'b0;
    check(v ? "R2 R3 cyc_toggles" : "R1 cyc_toggles hold", int'(cyc_toggles), e_cyc);
    check(v ? "R4 act_chains" : "R1 act_chains hold", int'(act_chains), e_act);
    check(st ? "R8 peak after start" : "R7 peak_toggles", int'(peak_toggles), e_peak);
    check(st ? "R8 hp after start" : hp_tag, int'(hp_flag), int'(e_hp));
    check(st ? "R8 act after start" : af_tag, int'(act_flag), int'(e_af));
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    scan_in = '0;
    chain_gate = '0;
    pattern_start = 1'b0;
    max_tr_pct = '0;
    max_act_pct = '0;
    for (int c = 0; c < NC; c++) mq[c] = '0;
    e_cyc = 0; e_act = 0; e_peak = 0; e_hp = 0; e_af = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in_ready in reset", int'(in_ready), 0);
    check("R9 cyc_toggles reset", int'(cyc_toggles), 0);
    check("R9 peak reset", int'(peak_toggles), 0);
    check("R9 flags reset", int'(hp_flag) + int'(act_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready out of reset", int'(in_ready), 1);

    // First shift after reset: toggles equal number of ones loaded (cells were 0).
    step(1'b1, 3'b111, 3'b101, 1'b1, 100, 100);
    check("R9 R2 zero cells then gated load", int'(cyc_toggles), 2);

    for (int trp = 0; trp <= 100; trp++) begin
      for (int k = 0; k < 64; k++) begin
        int ap;
        bit v;
        bit st;
        ap = (trp * 7 + k) % 101;
        v  = (k % 5) != 4;
        st = (k % 9) == 0;
        step(v, 3'(k), 3'(k >> 3), st, trp, ap);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule